// File: doc/BRIEF.md
# Dual Down-Counting Event Timer

This block holds two independent 32-bit down-counters that software programs through a small word-addressed register bus. The bus has a byte address, a write strobe, write data and registered read data. Each counter can be switched on or off. It can stop after one expiry or reload itself from a reload register. Its decrement pulse comes either from its own power-of-two prescaler running on the system clock or from an external reference tick, which is treated as a synchronous one-cycle enable.

When a counter expires, its sticky event flag is set. The flag of counter 1 is driven straight out as a level interrupt. The flags sit in one status word. Writing 0 to a flag's bit clears that flag, and writing 1 leaves it unchanged, so software can acknowledge one counter without disturbing the other. A typical setup uses counter 0 as a wrapping free-running timebase and counter 1 as a periodic or one-shot interrupt source.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is low.
- R2: The control word is at address 0x00. Counter 0 uses bit 0 for enable, bit 1 for auto-reload, bit 11 for the reference source and bits 21:19 for its prescale exponent. Counter 1 uses bit 2 for enable, bit 3 for auto-reload, bit 12 for the reference source and bits 24:22 for its prescale exponent. On readback the other bits are 0, so writing 0xFFFFFFFF reads back 0x01F8180F.
- R3: Counter 0 has its reload register at 0x10 and its value at 0x14. Counter 1 has its reload register at 0x18 and its value at 0x1C. A write to a value address loads the counter. A read of a value address returns the live count, one cycle after the address is presented.
- R4: A counter moves only on a decrement pulse while it is enabled. A disabled counter holds its value even when pulses arrive.
- R5: When its reference-source bit is set, a counter decrements once per cycle in which `ref_tick` is high, and not otherwise.
- R6: With the system clock selected and an exponent of n, a counter decrements exactly once every 2^n clock cycles. For n=0 that is every cycle.
- R7: A decrement pulse that arrives while the count is 0 is an expiry and sets the counter's flag. Without auto-reload the counter then stays at 0 and ignores further pulses, with no further expiries, until its value address is written.
- R8: With auto-reload, an expiry loads the reload value. A reload value of N-1 therefore gives one expiry every N pulses.
- R9: The status word is at 0x04, with counter 0's flag at bit 0 and counter 1's flag at bit 8. A write with a flag's bit at 0 clears that flag. A write with the bit at 1 leaves it unchanged.
- R10: When an expiry and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R11: `irq_out` is the level of counter 1's flag.
- R12: With reload value 0xFFFFFFFF and auto-reload, a counter at 0 wraps to 0xFFFFFFFF on its next pulse and keeps counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference decrement pulse, synchronous to clk |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Counter 1 event level |

## Verification
The bench lines up a reference pulse with a status write that clears counter 1's flag in the same cycle. A design that let the clear win would lose that event and keep the interrupt low. It walks a one-shot counter past zero and checks that the counter stays at 0 with no new flag until the value is rewritten. A design that re-armed on its own would set the flag again on every pulse. It also checks auto-reload at the point of expiry and the all-ones wrap; a design with an off-by-one there would show a count one higher or lower. Finally it measures the prescaled decrement rate over whole windows of 2^n cycles, which catches a divider that runs at the wrong power of two.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned PRE_W  = 3;
  localparam int unsigned NUM_CH = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h04;

  // Per-channel register addresses and control/status bit positions
  localparam logic [ADDR_W-1:0] A_RELOAD [NUM_CH] = '{8'h10, 8'h18};
  localparam logic [ADDR_W-1:0] A_VALUE  [NUM_CH] = '{8'h14, 8'h1C};
  localparam int unsigned EN_POS   [NUM_CH] = '{0, 2};
  localparam int unsigned AUTO_POS [NUM_CH] = '{1, 3};
  localparam int unsigned REF_POS  [NUM_CH] = '{11, 12};
  localparam int unsigned PRE_POS  [NUM_CH] = '{19, 22};
  localparam int unsigned FLAG_POS [NUM_CH] = '{0, 8};
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned PRE_W = 3,
  localparam int unsigned CNT_W = (1 << PRE_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] shift,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   full;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    full = ((CNT_W+1)'(1) << shift) - (CNT_W+1)'(1);
    mask = full[CNT_W-1:0];
    tick = ((cnt_q & mask) == mask);
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         auto_en,
  input  logic         step,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] count_q;
  logic         halted_q;
  logic         live_step;

  assign live_step = enable && step && !halted_q && !load_we;
  assign expire    = live_step && (count_q == '0);
  assign count     = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      halted_q <= 1'b0;
    end else if (load_we) begin
      count_q  <= load_val;
      halted_q <= 1'b0;
    end else if (live_step) begin
      if (count_q == '0) begin
        if (auto_en) count_q  <= reload_val;
        else         halted_q <= 1'b1;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dual_timer_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_out
);
  localparam logic [W-1:0] PRE_FIELD = W'((1 << PRE_W) - 1);

  function automatic logic [W-1:0] ctrl_mask();
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      m[EN_POS[i]]   = 1'b1;
      m[AUTO_POS[i]] = 1'b1;
      m[REF_POS[i]]  = 1'b1;
      m = m | (PRE_FIELD << PRE_POS[i]);
    end
    return m;
  endfunction

  localparam logic [W-1:0] CTRL_MASK = ctrl_mask();

  logic [W-1:0]              ctrl_q;
  logic [NUM_CH-1:0][W-1:0]  reload_q;
  logic [NUM_CH-1:0][W-1:0]  count;
  logic [NUM_CH-1:0]         expire;
  logic [NUM_CH-1:0]         ch_en;
  logic [NUM_CH-1:0]         ch_auto;
  logic [NUM_CH-1:0]         load_we;
  logic [NUM_CH-1:0]         flag_clr;
  logic [NUM_CH-1:0]         flag_q;
  logic [W-1:0]              rdata_q;
  logic [W-1:0]              status_word;

  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= '0;
    else if (bus_we && bus_addr == A_CTRL)  ctrl_q <= bus_wdata & CTRL_MASK;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic             pre_tick;
    logic             step;
    logic [PRE_W-1:0] shift;

    assign shift       = ctrl_q[PRE_POS[i] +: PRE_W];
    assign ch_en[i]    = ctrl_q[EN_POS[i]];
    assign ch_auto[i]  = ctrl_q[AUTO_POS[i]];
    assign step        = ctrl_q[REF_POS[i]] ? ref_tick : pre_tick;
    assign load_we[i]  = bus_we && (bus_addr == A_VALUE[i]);
    assign flag_clr[i] = bus_we && (bus_addr == A_STATUS) && !bus_wdata[FLAG_POS[i]];

    timer_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst   (rst),
      .shift (shift),
      .tick  (pre_tick)
    );

    timer_channel #(.W(W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .enable     (ch_en[i]),
      .auto_en    (ch_auto[i]),
      .step       (step),
      .load_we    (load_we[i]),
      .load_val   (bus_wdata),
      .reload_val (reload_q[i]),
      .count      (count[i]),
      .expire     (expire[i])
    );

    always_ff @(posedge clk) begin
      if (rst)                                    reload_q[i] <= '0;
      else if (bus_we && bus_addr == A_RELOAD[i]) reload_q[i] <= bus_wdata;
    end

    // An expiry in the same cycle as a clear keeps the flag set
    always_ff @(posedge clk) begin
      if (rst)              flag_q[i] <= 1'b0;
      else if (expire[i])   flag_q[i] <= 1'b1;
      else if (flag_clr[i]) flag_q[i] <= 1'b0;
    end
  end

  always_comb begin
    status_word = '0;
    for (int i = 0; i < NUM_CH; i++) status_word[FLAG_POS[i]] = flag_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (bus_addr == A_CTRL)   rdata_q <= ctrl_q;
      if (bus_addr == A_STATUS) rdata_q <= status_word;
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_addr == A_RELOAD[i]) rdata_q <= reload_q[i];
        if (bus_addr == A_VALUE[i])  rdata_q <= count[i];
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = flag_q[1];
endmodule

// File: rtl/dual_timer_checker.sv
module dual_timer_checker #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_out,
  input logic [N-1:0]      flag,
  input logic [N-1:0]      expire,
  input logic [N-1:0]      enable,
  input logic [N-1:0]      auto_en,
  input logic [N-1:0]      load_we,
  input logic [N-1:0]      clr,
  input logic [N-1:0][W-1:0] count,
  input logic [N-1:0][W-1:0] reload
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r7_oneshot_rests_at_zero: assert property (@(posedge clk) disable iff (rst)
      expire[i] && !auto_en[i] |=> count[i] == '0);
    a_r8_reload_on_expiry: assert property (@(posedge clk) disable iff (rst)
      expire[i] && auto_en[i] |=> count[i] == $past(reload[i]));
    a_r4_hold_while_off: assert property (@(posedge clk) disable iff (rst)
      !enable[i] && !load_we[i] |=> $stable(count[i]));
    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      expire[i] |=> flag[i]);
    a_r9_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
      clr[i] && !expire[i] |=> !flag[i]);
  end

  a_r11_irq_needs_expiry: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(expire[1]));
endmodule

bind dual_reload_timer dual_timer_checker #(.W(W), .N(dual_timer_pkg::NUM_CH)) u_checker (
  .clk     (clk),
  .rst     (rst),
  .irq_out (irq_out),
  .flag    (flag_q),
  .expire  (expire),
  .enable  (ch_en),
  .auto_en (ch_auto),
  .load_we (load_we),
  .clr     (flag_clr),
  .count   (count),
  .reload  (reload_q)
);

// File: tb/test_dual_reload_timer.sv
module test_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dual_reload_timer i_dual_reload_timer (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] rld;
    logic        auto_on;
    logic [7:0]  pulses;
    logic [31:0] exp_count;
    logic        exp_flag;
  } vec_t;

  // Counter 1 on the reference tick: start, reload, auto, pulses -> count, flag
  localparam vec_t VECS [7] = '{
    '{32'd5, 32'd0, 1'b0, 8'd3, 32'd2, 1'b0},
    '{32'd5, 32'd0, 1'b0, 8'd6, 32'd0, 1'b1},
    '{32'd5, 32'd0, 1'b0, 8'd9, 32'd0, 1'b1},
    '{32'd2, 32'd3, 1'b1, 8'd3, 32'd3, 1'b1},
    '{32'd2, 32'd3, 1'b1, 8'd7, 32'd3, 1'b1},
    '{32'd0, 32'd9, 1'b1, 8'd1, 32'd9, 1'b1},
    '{32'd7, 32'd1, 1'b1, 8'd0, 32'd7, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic rate(input logic [31:0] ctl, input int span, input logic [31:0] exp, input string tag);
    logic [31:0] a0, a1;
    wr(8'h14, 32'd1000);
    wr(8'h00, ctl);
    rd(8'h14, a0);
    repeat (span) @(negedge clk);
    a1 = bus_rdata;
    check(tag, a0 - a1, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    foreach (VECS[j]) begin end
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

    // R2: control readback of implemented bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d);
    check("R2 control readback", d, 32'h01F8_180F);
    wr(8'h00, 32'h0);

    // Vector table, R3 R7 R8 R9 R11
    foreach (VECS[j]) begin
      wr(8'h00, 32'h0000_1004 | (VECS[j].auto_on ? 32'h8 : 32'h0));
      wr(8'h18, VECS[j].rld);
      wr(8'h1C, VECS[j].start);
      wr(8'h04, 32'h0);
      pulse(int'(VECS[j].pulses));
      rd(8'h1C, d);
      check($sformatf("R3/R7/R8 vector %0d count", j), d, VECS[j].exp_count);
      rd(8'h04, d);
      check($sformatf("R9 vector %0d status", j), d, {23'b0, VECS[j].exp_flag, 8'b0});
      check($sformatf("R11 vector %0d irq", j), {31'b0, irq_out}, {31'b0, VECS[j].exp_flag});
    end

    // R4 and R5: disabled holds; no ref pulse means no movement
    wr(8'h00, 32'h0000_1000);
    wr(8'h1C, 32'd9);
    pulse(3);
    rd(8'h1C, d);
    check("R4 disabled holds", d, 32'd9);
    wr(8'h00, 32'h0000_1004);
    repeat (20) @(negedge clk);
    rd(8'h1C, d);
    check("R5 no ref pulse no decrement", d, 32'd9);
    pulse(2);
    rd(8'h1C, d);
    check("R5 ref pulses decrement", d, 32'd7);

    // R10: expiry and clear in the same cycle
    wr(8'h1C, 32'd0);
    wr(8'h04, 32'h0);
    @(negedge clk);
    ref_tick = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0; bus_we = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0; bus_we = 1'b0;
    rd(8'h04, d);
    check("R10 set wins over clear", d, 32'h100);

    // R7: halted counter ignores pulses until rewritten
    wr(8'h04, 32'h0);
    pulse(2);
    rd(8'h04, d);
    check("R7 no re-expiry while halted", d, 32'h0);
    wr(8'h1C, 32'd2);
    pulse(1);
    rd(8'h1C, d);
    check("R7 resumes after rewrite", d, 32'd1);

    // R9: write-zero clears per flag
    wr(8'h00, 32'h0000_1805);
    wr(8'h14, 32'd0);
    wr(8'h1C, 32'd0);
    pulse(1);
    rd(8'h04, d);
    check("R9 both flags set", d, 32'h101);
    wr(8'h04, 32'h001);
    rd(8'h04, d);
    check("R9 clear counter 1 only", d, 32'h001);
    check("R11 irq dropped", {31'b0, irq_out}, 32'h0);
    wr(8'h04, 32'h100);
    rd(8'h04, d);
    check("R9 clear counter 0", d, 32'h0);

    // R12: all-ones wrap on counter 0
    wr(8'h00, 32'h0000_0803);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'd0);
    pulse(1);
    rd(8'h14, d);
    check("R12 wrap to all ones", d, 32'hFFFF_FFFF);
    pulse(1);
    rd(8'h14, d);
    check("R12 keeps counting", d, 32'hFFFF_FFFE);

    // R6: prescaled rates on the system clock
    rate(32'h0000_0001, 10, 32'd10, "R6 divide by 1");
    rate(32'h0010_0001, 64, 32'd16, "R6 divide by 4");
    rate(32'h0028_0001, 128, 32'd4, "R6 divide by 32");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule